// File: doc/BRIEF.md
# Vector Equality Compare with Byte Predicate Select

This unit compares two wide vectors lane by lane for equality and stores the result in one of a small bank of predicate registers. The lane width is byte, halfword or word. A predicate register always keeps one bit per byte of the vector, whatever lane width produced it. A halfword or word result is therefore copied onto every byte bit its lane covers.

A second, purely combinational path reads one predicate register and builds an output vector byte by byte. Each output byte is taken from one of two source vectors, as the matching predicate bit selects. Because predicates are always byte-granular, the same select path serves results of every lane width.

A compare and a select may be issued in the same cycle. The compare lands on the clock edge. The select always sees the register contents from before that edge.

Top module: `vec_cmp_pred`

## Requirements
- R1: After reset every predicate register holds all zeros, so a select returns the second source vector in full.
- R2: With lane-size code 2'b00 (byte), predicate bit i is 1 exactly when byte i of the two compare operands is equal.
- R3: With lane-size code 2'b01 (halfword), predicate bits 2j and 2j+1 both equal the equality of halfword j (bytes 2j and 2j+1).
- R4: With lane-size code 2'b10 (word), predicate bits 4k to 4k+3 all equal the equality of word k (bytes 4k to 4k+3).
- R5: Lane-size code 2'b11 behaves exactly like code 2'b10.
- R6: A compare writes only the register named by its destination index, and only when the compare enable is high. All other registers keep their values, and with enable low no register changes.
- R7: For each byte position i, the select output byte i is byte i of the first source when bit i of the chosen predicate is 1, and byte i of the second source otherwise.
- R8: When a compare and a select name the same register in the same cycle, the select output reflects the value held before that clock edge. The new value appears from the next cycle.
- R9: Byte i occupies bits 8i+7 to 8i of a vector, with byte 0 in the least significant bits, and it maps to predicate bit i.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_en_i | input | 1 | Compare enable; writes a predicate on the next edge |
| cmp_a_i | input | VEC_W | First compare operand |
| cmp_b_i | input | VEC_W | Second compare operand |
| cmp_size_i | input | 2 | Lane size: 00 byte, 01 halfword, 10 or 11 word |
| cmp_dst_i | input | IDX_W | Destination predicate index for the compare |
| sel_idx_i | input | IDX_W | Predicate index read by the select |
| sel_a_i | input | VEC_W | Source taken where the predicate bit is 1 |
| sel_b_i | input | VEC_W | Source taken where the predicate bit is 0 |
| sel_y_o | output | VEC_W | Select result |

## Verification
The embedded checks assume that the lane-size code and both indices are known, non-X values whenever reset is released. They also assume that the destination index stays below the number of predicate registers. The stimulus keeps every index drawn within 0 to 3 and holds all inputs at defined values from time zero. Random second operands are built by perturbing a random copy of the first, so that equal and unequal lanes both occur often at every lane size.

// File: rtl/vec_cmp_pred_pkg.sv
package vec_cmp_pred_pkg;
  typedef enum logic [1:0] {
    LANE_BYTE  = 2'b00,
    LANE_HALF  = 2'b01,
    LANE_WORD  = 2'b10,
    LANE_WORDX = 2'b11
  } lane_size_e;
endpackage

// File: rtl/vcp_lane_cmp.sv
module vcp_lane_cmp #(
  parameter int VEC_W = 512,
  parameter int NB    = VEC_W / 8
) (
  input  logic [VEC_W-1:0]               a_i,
  input  logic [VEC_W-1:0]               b_i,
  input  vec_cmp_pred_pkg::lane_size_e   size_i,
  output logic [NB-1:0]                  mask_o
);
  import vec_cmp_pred_pkg::*;
  localparam int NH = NB / 2;
  localparam int NW = NB / 4;

  logic [NB-1:0] byte_eq;
  logic [NH-1:0] half_eq;
  logic [NW-1:0] word_eq;
  logic [NB-1:0] mask_half;
  logic [NB-1:0] mask_word;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign byte_eq[i] = (a_i[8*i +: 8] == b_i[8*i +: 8]);
  end

  // wider lanes reuse byte comparators and fan back out to byte bits
  for (genvar j = 0; j < NH; j++) begin : g_half
    assign half_eq[j]        = &byte_eq[2*j +: 2];
    assign mask_half[2*j +: 2] = {2{half_eq[j]}};
  end

  for (genvar k = 0; k < NW; k++) begin : g_word
    assign word_eq[k]        = &byte_eq[4*k +: 4];
    assign mask_word[4*k +: 4] = {4{word_eq[k]}};
  end

  always_comb begin
    unique case (size_i)
      LANE_BYTE: mask_o = byte_eq;
      LANE_HALF: mask_o = mask_half;
      default:   mask_o = mask_word;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      if (mask_o[i] === 1'b1)
        assert_bit_eq_R2: assert (a_i[8*i +: 8] == b_i[8*i +: 8])
          else $error("mask bit set on unequal byte");
    end
    if (size_i === LANE_WORD || size_i === LANE_WORDX) begin
      for (int k = 0; k < NW; k++) begin
        if (mask_o[4*k] === 1'b1)
          assert_word_eq_R5: assert (a_i[32*k +: 32] == b_i[32*k +: 32])
            else $error("word mask set on unequal word");
      end
    end
  end
endmodule

// File: rtl/vcp_pred_bank.sv
module vcp_pred_bank #(
  parameter int NUM_PRED = 4,
  parameter int NB       = 64,
  parameter int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [NB-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [NB-1:0]    rd_data_o
);
  logic [NB-1:0] q [NUM_PRED];

  for (genvar r = 0; r < NUM_PRED; r++) begin : g_reg
    logic hit;
    assign hit = we_i && (wr_idx_i == IDX_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q[r] <= '0;
      else if (hit) q[r] <= wr_data_i;
    end

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wr_idx_i == IDX_W'(r)) |=> $stable(q[r]));

    assert_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wr_idx_i == IDX_W'(r)) |=> q[r] == $past(wr_data_i));
  end

  // read path is taken before the edge: old contents on a same-cycle write
  assign rd_data_o = q[rd_idx_i];
endmodule

// File: rtl/vcp_byte_sel.sv
module vcp_byte_sel #(
  parameter int VEC_W = 512,
  parameter int NB    = VEC_W / 8
) (
  input  logic [NB-1:0]    pred_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] y_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign y_o[8*i +: 8] = pred_i[i] ? a_i[8*i +: 8] : b_i[8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      if (pred_i[i] === 1'b1)
        assert_pick_a_R7: assert (y_o[8*i +: 8] == a_i[8*i +: 8])
          else $error("byte not from first source");
      else if (pred_i[i] === 1'b0)
        assert_pick_b_R7: assert (y_o[8*i +: 8] == b_i[8*i +: 8])
          else $error("byte not from second source");
    end
  end
endmodule

// File: rtl/vec_cmp_pred.sv
module vec_cmp_pred #(
  parameter int VEC_W    = 512,
  parameter int NUM_PRED = 4,
  parameter int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_en_i,
  input  logic [VEC_W-1:0] cmp_a_i,
  input  logic [VEC_W-1:0] cmp_b_i,
  input  logic [1:0]       cmp_size_i,
  input  logic [IDX_W-1:0] cmp_dst_i,
  input  logic [IDX_W-1:0] sel_idx_i,
  input  logic [VEC_W-1:0] sel_a_i,
  input  logic [VEC_W-1:0] sel_b_i,
  output logic [VEC_W-1:0] sel_y_o
);
  import vec_cmp_pred_pkg::*;
  localparam int NB = VEC_W / 8;

  lane_size_e    size;
  logic [NB-1:0] cmp_mask;
  logic [NB-1:0] pred_rd;

  assign size = lane_size_e'(cmp_size_i);

  vcp_lane_cmp #(.VEC_W(VEC_W), .NB(NB)) u_cmp (
    .a_i    (cmp_a_i),
    .b_i    (cmp_b_i),
    .size_i (size),
    .mask_o (cmp_mask)
  );

  vcp_pred_bank #(.NUM_PRED(NUM_PRED), .NB(NB), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cmp_en_i),
    .wr_idx_i  (cmp_dst_i),
    .wr_data_i (cmp_mask),
    .rd_idx_i  (sel_idx_i),
    .rd_data_o (pred_rd)
  );

  vcp_byte_sel #(.VEC_W(VEC_W), .NB(NB)) u_sel (
    .pred_i (pred_rd),
    .a_i    (sel_a_i),
    .b_i    (sel_b_i),
    .y_o    (sel_y_o)
  );

  assert_idx_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i |-> (int'(cmp_dst_i) < NUM_PRED));

  // same-cycle write and read of one register: read keeps the old value
  assert_rd_before_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && cmp_dst_i == sel_idx_i) |=> (pred_rd == $past(cmp_mask)) || (sel_idx_i != $past(sel_idx_i)));
endmodule

// File: tb/sim_vec_cmp_pred.sv
module sim_vec_cmp_pred;
  localparam int VW = 512;
  localparam int NB = VW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_en = 1'b0;
  logic [VW-1:0] cmp_a = '0, cmp_b = '0;
  logic [1:0]    cmp_size = 2'b00;
  logic [1:0]    cmp_dst = 2'd0, sel_idx = 2'd0;
  logic [VW-1:0] sel_a = '0, sel_b = '0;
  logic [VW-1:0] sel_y;

  logic [NB-1:0] mdl [4];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vec_cmp_pred u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmp_en_i(cmp_en), .cmp_a_i(cmp_a),
    .cmp_b_i(cmp_b), .cmp_size_i(cmp_size), .cmp_dst_i(cmp_dst),
    .sel_idx_i(sel_idx), .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_y_o(sel_y)
  );

  function automatic logic [NB-1:0] exp_mask(logic [VW-1:0] a, logic [VW-1:0] b, logic [1:0] sz);
    int esz = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    logic [NB-1:0] m = '0;
    for (int e = 0; e < NB / esz; e++) begin
      logic eq = 1'b1;
      for (int k = 0; k < esz; k++)
        if (a[8*(e*esz+k) +: 8] != b[8*(e*esz+k) +: 8]) eq = 1'b0;
      for (int k = 0; k < esz; k++) m[e*esz+k] = eq;
    end
    return m;
  endfunction

  function automatic logic [VW-1:0] exp_sel(logic [NB-1:0] p, logic [VW-1:0] a, logic [VW-1:0] b);
    logic [VW-1:0] y;
    for (int i = 0; i < NB; i++) y[8*i +: 8] = p[i] ? a[8*i +: 8] : b[8*i +: 8];
    return y;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW / 32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] near_vec(logic [VW-1:0] a);
    logic [VW-1:0] v = a;
    for (int i = 0; i < NB; i++)
      if ($urandom % 6 == 0) v[8*i +: 8] = v[8*i +: 8] ^ 8'(1 + $urandom % 255);
    return v;
  endfunction

  // inputs are set after a falling edge; check before the rising edge, then update model
  task automatic cycle(string tag);
    logic [VW-1:0] exp;
    #1;
    exp = exp_sel(mdl[sel_idx], sel_a, sel_b);
    checks++;
    if (sel_y !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, sel_y, exp);
    end
    @(posedge clk);
    if (cmp_en) mdl[cmp_dst] = exp_mask(cmp_a, cmp_b, cmp_size);
    @(negedge clk);
  endtask

  task automatic peek(logic [1:0] idx, string tag);
    cmp_en = 1'b0; sel_idx = idx; sel_a = '1; sel_b = '0;
    cycle(tag);
  endtask

  task automatic do_cmp(logic [1:0] sz, logic [1:0] dst, logic [VW-1:0] a, logic [VW-1:0] b);
    cmp_en = 1'b1; cmp_size = sz; cmp_dst = dst; cmp_a = a; cmp_b = b;
    sel_idx = 2'(~dst); sel_a = rand_vec(); sel_b = rand_vec();
    cycle("R7");
    cmp_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b;
    void'($urandom(32'd2024));
    for (int r = 0; r < 4; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) peek(2'(r), "R1");

    // byte lanes: bytes 0, 5, 63 differ
    a = rand_vec(); b = a;
    b[7:0] = ~b[7:0]; b[47:40] = b[47:40] ^ 8'h10; b[511:504] = ~b[511:504];
    do_cmp(2'b00, 2'd1, a, b);
    peek(2'd1, "R2 R9");

    // halfword: byte 6 differs, halfword 3 cleared
    a = rand_vec(); b = a; b[55:48] = b[55:48] ^ 8'h01;
    do_cmp(2'b01, 2'd2, a, b);
    peek(2'd2, "R3");

    // word: byte 9 differs, word 2 cleared
    a = rand_vec(); b = a; b[79:72] = b[79:72] ^ 8'h80;
    do_cmp(2'b10, 2'd3, a, b);
    peek(2'd3, "R4");

    // code 11 as word: byte 1 differs
    a = rand_vec(); b = a; b[15:8] = ~b[15:8];
    do_cmp(2'b11, 2'd0, a, b);
    peek(2'd0, "R5");

    // enable low: nothing written
    cmp_en = 1'b0; cmp_size = 2'b00; cmp_dst = 2'd1; cmp_a = '0; cmp_b = '0;
    sel_idx = 2'd0; sel_a = rand_vec(); sel_b = rand_vec();
    cycle("R6");
    for (int r = 0; r < 4; r++) peek(2'(r), "R6");

    // same-cycle write and read of register 2
    a = rand_vec(); b = near_vec(a);
    cmp_en = 1'b1; cmp_size = 2'b00; cmp_dst = 2'd2; cmp_a = a; cmp_b = b;
    sel_idx = 2'd2; sel_a = rand_vec(); sel_b = rand_vec();
    cycle("R8");
    peek(2'd2, "R8");

    // random mix
    for (int n = 0; n < 400; n++) begin
      cmp_en   = ($urandom % 3) != 0;
      cmp_size = 2'($urandom);
      cmp_dst  = 2'($urandom);
      sel_idx  = 2'($urandom);
      cmp_a    = rand_vec();
      cmp_b    = ($urandom % 4 == 0) ? cmp_a : near_vec(cmp_a);
      sel_a    = rand_vec();
      sel_b    = rand_vec();
      case (cmp_size)
        2'b00:   cycle("R2 R7");
        2'b01:   cycle("R3 R7");
        2'b10:   cycle("R4 R7");
        default: cycle("R5 R7");
      endcase
    end
    for (int r = 0; r < 4; r++) peek(2'(r), "R6");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule